// File: doc/BRIEF.md
# Lagged-Ready Streaming Sink Adapter

This block sits between a streaming source whose transfers follow a delayed ready and a consumer that expects a plain valid/ready handshake. The upstream side runs on a configurable ready latency: a beat may arrive a fixed number of cycles after the adapter raised ready. It also has a configurable allowance: once that delayed ready has dropped, the source may still send a fixed number of beats.

Every beat captured on the upstream side goes into a small circular skid store. The store holds at least latency + allowance + 1 entries, plus a parameterised slack that sets the throughput. The adapter computes its upstream ready from the space left in the store and registers it. It deasserts ready early enough that every beat the source may still legally send has room. The downstream side empties the store in arrival order, with no extra latency.

Beats the source presents outside its permitted cycles are not captured. The adapter does not flag them as errors. Data width, ready latency, allowance and slack are all parameters.

Top module: `lagged_ready_sink`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after a reset edge, `up_ready` and `dn_valid` are both 0.
- R2: `up_ready` is a flop output. In each cycle it equals 1 exactly when DEPTH minus the number of stored beats exceeds READY_LAT + ALLOWANCE, where DEPTH = READY_LAT + ALLOWANCE + 1 + SLACK.
- R3: A beat is captured in cycle t when `up_valid` is 1 in cycle t and `up_ready` was 1 in at least one of the cycles t-READY_LAT-k, for k from 0 to ALLOWANCE.
- R4: A beat presented with `up_valid` = 1 in a cycle outside that window is ignored. The count of stored beats and the data delivered downstream do not change because of it.
- R5: Every captured beat leaves on `dn_data`, exactly once and in capture order.
- R6: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` stays 1 and `dn_data` holds its value in the next cycle.
- R7: With a source that keeps to R3, the number of stored beats never exceeds DEPTH.
- R8: With READY_LAT = 0 and ALLOWANCE = 0, a beat transfers only in a cycle where `up_valid` and `up_ready` are both 1.
- R9: `dn_valid` is 1 exactly when at least one beat is stored. A beat captured at a clock edge is offered downstream in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Source presents a beat this cycle |
| up_data | input | DATA_W | Beat payload from the source |
| up_ready | output | 1 | Registered space indication toward the source |
| dn_valid | output | 1 | A stored beat is on offer to the consumer |
| dn_data | output | DATA_W | Oldest stored beat |
| dn_ready | input | 1 | Consumer takes the offered beat when 1 with dn_valid |

## Verification
The same adapter is built in four latency/allowance pairs, including the plain handshake case (0,0) and a latency larger than the allowance (3,1).

A long random phase, with random valid density and random consumer stalls, checks that ready, occupancy and in-order delivery agree with a model that reads only the port history. A phase with the consumer stalled and the source sending in every permitted cycle drives the store to its limit, which shows whether the ready threshold leaves room for every beat still allowed in flight.

A phase where the source deliberately sends outside the permitted window separates correct gating from capturing every valid. A final drain confirms that nothing was lost or duplicated.

// File: rtl/lrs_pkg.sv
// Package lrs_pkg
// Shared helpers for the lagged-ready sink adapter.
// Assumes: callers pass depths of at least 1.
package lrs_pkg;

    // Width of a pointer that indexes `depth` entries (never zero).
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that must represent 0..`limit` inclusive.
    function automatic int count_width(input int limit);
        return (limit > 0) ? $clog2(limit + 1) : 1;
    endfunction

endpackage

// File: rtl/lrs_ready_delay.sv
// Module lrs_ready_delay
// Delays the registered ready by LAT cycles, so the result lines up with
// the cycle in which a source that saw that ready may present a beat.
// Assumes: LAT >= 0; LAT = 0 passes ready straight through.
module lrs_ready_delay #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_in,
    output logic rdy_out
);

    generate
        if (LAT == 0) begin : g_direct
            assign rdy_out = rdy_in;
        end else begin : g_shift
            logic [LAT-1:0] sh_q;

            // Shift the ready history by one stage every cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= '0;
                end else begin
                    sh_q <= (sh_q << 1) | LAT'(rdy_in);
                end
            end

            assign rdy_out = sh_q[LAT-1];

            // Output repeats the input exactly LAT cycles later.
            p_delay_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
                rdy_in |-> ##LAT (rdy_out || !rst_n));
        end
    endgenerate

endmodule

// File: rtl/lrs_allow_window.sv
// Module lrs_allow_window
// Turns the delayed ready into a capture permit that stays open for ALLOW
// further cycles after the delayed ready falls.
// Assumes: ALLOW >= 0; ALLOW = 0 makes the permit equal the delayed ready.
module lrs_allow_window
    import lrs_pkg::*;
#(
    parameter int ALLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_ready,
    output logic permit
);

    generate
        if (ALLOW == 0) begin : g_none
            assign permit = dly_ready;
        end else begin : g_tail
            localparam int CW = count_width(ALLOW);
            logic [CW-1:0] tail_q;

            // Reload the tail while ready is seen, otherwise count it down.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tail_q <= '0;
                end else if (dly_ready) begin
                    tail_q <= CW'(ALLOW);
                end else if (tail_q != '0) begin
                    tail_q <= tail_q - CW'(1);
                end
            end

            assign permit = dly_ready || (tail_q != '0);

            // The first cycle after the delayed ready falls is still permitted.
            p_tail_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (dly_ready && $past(rst_n)) |=> permit);
        end
    endgenerate

endmodule

// File: rtl/lrs_skid_store.sv
// Module lrs_skid_store
// Circular first-in first-out store for captured beats. The head entry is
// offered combinationally. The next-cycle level is exported so the parent
// can register its ready decision.
// Assumes: push never happens on a full store unless a pop happens with it.
module lrs_skid_store
    import lrs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 push,
    input  logic [DATA_W-1:0]                    push_data,
    input  logic                                 pop,
    output logic [DATA_W-1:0]                    head_data,
    output logic [count_width(DEPTH)-1:0]        level,
    output logic [count_width(DEPTH)-1:0]        level_nxt
);

    localparam int PW = ptr_width(DEPTH);
    localparam int LW = count_width(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     wr_ptr_q;
    logic [PW-1:0]     rd_ptr_q;
    logic [LW-1:0]     level_q;

    // Advance a pointer with wrap at the last entry.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // Next level from the push/pop pair.
    always_comb begin
        unique case ({push, pop})
            2'b10:   level_nxt = level_q + LW'(1);
            2'b01:   level_nxt = level_q - LW'(1);
            default: level_nxt = level_q;
        endcase
    end

    // Write captured data into the entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            level_q <= level_nxt;
        end
    end

    assign head_data = mem_q[rd_ptr_q];
    assign level     = level_q;

    // A push without a pop needs a free entry.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (level_q < LW'(DEPTH)));

    // A pop needs a stored entry.
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level_q != '0));

endmodule

// File: rtl/lagged_ready_sink.sv
// Module lagged_ready_sink
// Sink adapter for a source that follows a delayed ready (READY_LAT cycles)
// and may run ALLOWANCE beats past it. The adapter presents a zero-latency
// valid/ready interface downstream.
// Assumes: the source only drives valid inside the permitted window; beats
// outside it are dropped silently. The store depth covers every beat that
// may still arrive once ready is withdrawn.
module lagged_ready_sink
    import lrs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int READY_LAT = 1,
    parameter int ALLOWANCE = 2,
    parameter int SLACK     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ready
);

    localparam int DEPTH    = READY_LAT + ALLOWANCE + 1 + SLACK;
    localparam int LW       = count_width(DEPTH);
    localparam int LIMIT    = DEPTH - READY_LAT - ALLOWANCE - 1;
    localparam logic [LW-1:0] READY_LIMIT = LW'(LIMIT);

    logic          ready_q;
    logic          dly_ready;
    logic          permit;
    logic          push;
    logic          pop;
    logic [LW-1:0] level;
    logic [LW-1:0] level_nxt;

    lrs_ready_delay #(
        .LAT(READY_LAT)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_in  (ready_q),
        .rdy_out (dly_ready)
    );

    lrs_allow_window #(
        .ALLOW(ALLOWANCE)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .dly_ready (dly_ready),
        .permit    (permit)
    );

    assign push = up_valid && permit;
    assign pop  = dn_valid && dn_ready;

    lrs_skid_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (up_data),
        .pop       (pop),
        .head_data (dn_data),
        .level     (level),
        .level_nxt (level_nxt)
    );

    // Register ready: keep it high only while the remaining space covers
    // every beat the source may still send once ready is withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= (level_nxt <= READY_LIMIT);
        end
    end

    assign up_ready = ready_q;
    assign dn_valid = (level != '0);

    // Reset clears both handshake outputs in the following cycle.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!up_ready && !dn_valid));

    // Ready never shows while the space is at or below the in-flight bound.
    p_space_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (level <= READY_LIMIT));

    // Valid outside the permitted window does not raise the level.
    p_ignore_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!permit && $past(rst_n)) |=> (level <= $past(level)));

    // Stalled downstream holds the offered beat.
    p_hold_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // A captured beat is offered downstream at the next cycle.
    p_offer_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> dn_valid);

endmodule

// File: tb/lagged_ready_sink_tb_top.sv
// Runs one adapter configuration against a compliant source model with
// random downstream stalls; reports its check counts to the top bench.
module lrs_cfg_run #(
    parameter int RL    = 0,
    parameter int RA    = 0,
    parameter int SLACK = 2,
    parameter int W     = 16,
    parameter int SEED  = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_chk,
    output int   n_bad
);

    localparam int DEPTH = RL + RA + 1 + SLACK;

    logic         up_valid;
    logic [W-1:0] up_data;
    logic         up_ready;
    logic         dn_valid;
    logic [W-1:0] dn_data;
    logic         dn_ready;

    logic [W-1:0] exp_q [$];
    logic         hist [RL+RA+1];
    logic [W-1:0] seq;
    logic         prev_stall;
    logic [W-1:0] prev_data;

    lagged_ready_sink #(
        .DATA_W   (W),
        .READY_LAT(RL),
        .ALLOWANCE(RA),
        .SLACK    (SLACK)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(up_valid),
        .up_data (up_data),
        .up_ready(up_ready),
        .dn_valid(dn_valid),
        .dn_data (dn_data),
        .dn_ready(dn_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (RL=%0d RA=%0d) actual=%0d expected=%0d", req, RL, RA, act, exp);
        end
    endtask

    // Permitted when ready was seen RL+k cycles ago for some k in 0..RA.
    function automatic bit permitted();
        for (int k = 0; k <= RA; k++) begin
            if (hist[RL + k]) return 1'b1;
        end
        return 1'b0;
    endfunction

    // One cycle: observe at the falling edge, then drive the next inputs.
    task automatic step(input int vprob, input int rprob, input bit illegal, input string tag);
        int occ;
        bit ok;
        @(negedge clk);
        for (int i = RL + RA; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = up_ready;
        occ = exp_q.size();
        chk(up_ready == ((DEPTH - occ) > (RL + RA)), tag, int'(up_ready), int'((DEPTH - occ) > (RL + RA)));
        chk(dn_valid == (occ != 0), "R9", int'(dn_valid), int'(occ != 0));
        chk(occ <= DEPTH, "R7", occ, DEPTH);
        if (prev_stall) chk(dn_valid && (dn_data == prev_data), "R6", int'(dn_data), int'(prev_data));
        dn_ready = (($urandom % 100) < rprob);
        if (dn_valid && dn_ready) begin
            if (occ != 0) begin
                chk(dn_data == exp_q[0], (RL == 0 && RA == 0) ? "R8" : "R5", int'(dn_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
        prev_stall = dn_valid && !dn_ready;
        prev_data  = dn_data;
        ok = permitted();
        up_valid = 1'b0;
        if (ok) begin
            if (($urandom % 100) < vprob) begin
                up_valid = 1'b1;
                up_data  = seq;
                exp_q.push_back(seq);
                seq = seq + 1'b1;
            end
        end else if (illegal && (($urandom % 100) < 60)) begin
            up_valid = 1'b1;
            up_data  = ~seq;
        end
    endtask

    initial begin
        done       = 1'b0;
        n_chk      = 0;
        n_bad      = 0;
        up_valid   = 1'b0;
        up_data    = '0;
        dn_ready   = 1'b0;
        seq        = '0;
        prev_stall = 1'b0;
        prev_data  = '0;
        for (int i = 0; i <= RL + RA; i++) hist[i] = 1'b0;
        void'($urandom(SEED));
        // R1: both handshake outputs quiet during reset.
        repeat (3) @(negedge clk);
        chk(!up_ready && !dn_valid, "R1", int'(up_ready) + int'(dn_valid), 0);
        @(posedge rst_n);
        // R2/R3: random traffic with random consumer stalls.
        for (int c = 0; c < 1500; c++) step(70, 50, 1'b0, "R2/R3");
        // R7: consumer stalled, source sends in every permitted cycle.
        for (int c = 0; c < 60; c++) step(100, 0, 1'b0, "R2/R7");
        // R4: source also drives valid outside its window.
        for (int c = 0; c < 300; c++) step(50, 30, 1'b1, "R4");
        // R5: drain everything that was captured.
        for (int c = 0; c < DEPTH + 10; c++) step(0, 100, 1'b0, "R2/R5");
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        done = 1'b1;
    end

endmodule

// Top bench: clock, reset, four configurations, watchdog and summary.
module lagged_ready_sink_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk;
    logic rst_n;
    logic d0, d1, d2, d3;
    int   c0, c1, c2, c3;
    int   b0, b1, b2, b3;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    lrs_cfg_run #(.RL(0), .RA(0), .SLACK(2), .SEED(11)) u_c0 (.clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_bad(b0));
    lrs_cfg_run #(.RL(0), .RA(1), .SLACK(1), .SEED(23)) u_c1 (.clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_bad(b1));
    lrs_cfg_run #(.RL(1), .RA(2), .SLACK(2), .SEED(37)) u_c2 (.clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_bad(b2));
    lrs_cfg_run #(.RL(3), .RA(1), .SLACK(3), .SEED(41)) u_c3 (.clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_bad(b3));

    initial begin
        int total;
        int bad;
        int cyc;
        cyc = 0;
        while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1 && d3 === 1'b1) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        total = c0 + c1 + c2 + c3;
        bad   = b0 + b1 + b2 + b3;
        if (cyc >= WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: run incomplete actual=%0d expected<%0d", cyc, WATCHDOG);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end

endmodule